// File: doc/BRIEF.md
# Compare-match timer

This block is a 16-bit free-running up-counter with two compare registers, sticky event flags and one interrupt request. Software reaches every register through a byte-wide, eight-location register window. It writes with a one-cycle strobe and reads combinationally. A separate count-enable input paces the counter. Each cycle in which that input is high is one count tick.

On each tick the block compares the counter with both compare values and latches any match in a status flag. If the clear control bit is set, a match on compare A first reloads the counter with zero. The counter then advances by one, and a wrap from 0xFFFF to 0x0000 latches an overflow flag. Each flag can be routed to the interrupt request by its own enable bit. A vector output names the most urgent pending event.

Top module: `cmp_timer`

## Requirements
- R1: After reset the counter reads 0x0000, both compare values read 0xFFFF, and all flags, enables, control bits and the byte at offset 6 read 0. The interrupt request is low and the vector is 0.
- R2: The window is laid out as follows:
  - offset 0 holds the enables: bit0 compare A, bit1 compare B, bit2 overflow.
  - offset 1 holds the status: bit0 flag A, bit1 flag B, bit2 overflow flag, bit3 the read/write clear-on-A control.
  - offsets 2 and 3 are the counter's high and low bytes.
  - offset 6 is a plain read/write byte.
  - offset 7 bit0 is the compare select.
  - Bits not listed read 0.
- R3: Offsets 4 (high byte) and 5 (low byte) reach compare A when the select bit is 0 and compare B when it is 1, for both writes and reads.
- R4: The counter changes only in a cycle with the tick high, or in a cycle with a bus write to offset 2 or 3. A counter write in the same cycle as a tick stores the written byte, and that tick has no effect at all: no increment and no flags.
- R5: A tick while the counter equals compare A sets flag A. If the clear-on-A bit is 1, the counter is reloaded with 0 and then incremented, so it reads 0x0001 afterwards, with no overflow flag.
- R6: A tick while the counter equals compare B sets flag B and never changes the counter's normal increment.
- R7: A tick that takes the counter from 0xFFFF to 0x0000 sets the overflow flag.
- R8: Writing offset 1 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. An event in the same cycle as a clearing write sets its flag.
- R9: The interrupt request is high exactly while some flag is set together with its enable bit.
- R10: The vector is 18 when overflow is pending and enabled. Otherwise it is 17 for compare B, then 16 for compare A, and 0 when nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable; one tick per high cycle |
| bus_addr | input | 3 | Register window offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request |
| irq_vec | output | 5 | Vector of the highest-priority pending event |

## Verification
A wrong flag or enable is visible at irq and irq_vec in the very next cycle. It is also visible in the status byte as soon as it is read. A counter that drifts by one tick, or a compare register that the select bit steered wrongly, shows up the same way. In each case a flag sets one tick early, one tick late, or never, and the counter readback differs from the arithmetic expectation after that tick. The bench therefore reads the counter and status after every tick in the compare and wrap runs. It also walks all 64 combinations of flags and enables to pin down the priority of the vector.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int VEC_W  = 5;
    localparam int NUM_CMP = 2;

    localparam logic [VEC_W-1:0] VEC_NONE = 5'd0;
    localparam logic [VEC_W-1:0] VEC_CA   = 5'd16;
    localparam logic [VEC_W-1:0] VEC_CB   = 5'd17;
    localparam logic [VEC_W-1:0] VEC_OVF  = 5'd18;

    typedef enum logic [ADDR_W-1:0] {
        OFF_IEN    = 3'd0,
        OFF_STAT   = 3'd1,
        OFF_CNT_HI = 3'd2,
        OFF_CNT_LO = 3'd3,
        OFF_CMP_HI = 3'd4,
        OFF_CMP_LO = 3'd5,
        OFF_TCTL   = 3'd6,
        OFF_OCTL   = 3'd7
    } reg_off_e;

    typedef struct packed {
        logic ovf;
        logic cmp_b;
        logic cmp_a;
    } ev_t;

    function automatic logic [VEC_W-1:0] pick_vector(input ev_t pend);
        if (pend.ovf)        return VEC_OVF;
        else if (pend.cmp_b) return VEC_CB;
        else if (pend.cmp_a) return VEC_CA;
        else                 return VEC_NONE;
    endfunction
endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
    import cmp_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic [CNT_W-1:0]  cnt,
    input  ev_t               flags,
    output logic [DATA_W-1:0] rdata,
    output logic              cnt_wr_hi,
    output logic              cnt_wr_lo,
    output ev_t               keep,
    output ev_t               en,
    output logic              clr_a,
    output logic [CNT_W-1:0]  cmp_a,
    output logic [CNT_W-1:0]  cmp_b
);
    logic [CNT_W-1:0]  cmp_q [NUM_CMP];
    logic [DATA_W-1:0] tctl_q;
    logic              sel_q;
    ev_t               en_q;
    logic              clr_q;

    assign cnt_wr_hi = we && (addr == OFF_CNT_HI);
    assign cnt_wr_lo = we && (addr == OFF_CNT_LO);
    assign keep      = (we && (addr == OFF_STAT)) ? ev_t'(wdata[2:0]) : ev_t'(3'b111);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            clr_q  <= 1'b0;
            sel_q  <= 1'b0;
            tctl_q <= '0;
        end else if (we) begin
            case (addr)
                OFF_IEN:  en_q   <= ev_t'(wdata[2:0]);
                OFF_STAT: clr_q  <= wdata[3];
                OFF_TCTL: tctl_q <= wdata;
                OFF_OCTL: sel_q  <= wdata[0];
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_q[g] <= '1;
            end else if (we && (sel_q == g[0])) begin
                if (addr == OFF_CMP_HI)
                    cmp_q[g] <= {wdata, cmp_q[g][DATA_W-1:0]};
                else if (addr == OFF_CMP_LO)
                    cmp_q[g] <= {cmp_q[g][CNT_W-1:DATA_W], wdata};
            end
        end
    end

    assign cmp_a = cmp_q[0];
    assign cmp_b = cmp_q[1];
    assign en    = en_q;
    assign clr_a = clr_q;

    always_comb begin
        rdata = '0;
        case (addr)
            OFF_IEN:    rdata = {5'd0, en_q};
            OFF_STAT:   rdata = {4'd0, clr_q, flags};
            OFF_CNT_HI: rdata = cnt[CNT_W-1:DATA_W];
            OFF_CNT_LO: rdata = cnt[DATA_W-1:0];
            OFF_CMP_HI: rdata = cmp_q[sel_q][CNT_W-1:DATA_W];
            OFF_CMP_LO: rdata = cmp_q[sel_q][DATA_W-1:0];
            OFF_TCTL:   rdata = tctl_q;
            OFF_OCTL:   rdata = {7'd0, sel_q};
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/cmp_timer_core.sv
module cmp_timer_core
    import cmp_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [DATA_W-1:0] wdata,
    input  ev_t               keep,
    input  logic              clr_a,
    input  logic [CNT_W-1:0]  cmp_a,
    input  logic [CNT_W-1:0]  cmp_b,
    output logic [CNT_W-1:0]  cnt,
    output ev_t               flags
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] base;
    logic [CNT_W:0]   sum;
    logic             step;
    ev_t              flags_q;
    ev_t              hit;

    assign step      = tick && !(wr_hi || wr_lo);
    assign hit.cmp_a = (cnt_q == cmp_a);
    assign hit.cmp_b = (cnt_q == cmp_b);
    assign base      = (hit.cmp_a && clr_a) ? '0 : cnt_q;
    assign sum       = (CNT_W+1)'(base) + (CNT_W+1)'(1);
    assign hit.ovf   = sum[CNT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            flags_q <= '0;
        end else begin
            if (wr_hi)
                cnt_q <= {wdata, cnt_q[DATA_W-1:0]};
            else if (wr_lo)
                cnt_q <= {cnt_q[CNT_W-1:DATA_W], wdata};
            else if (step)
                cnt_q <= sum[CNT_W-1:0];
            flags_q <= (flags_q & keep) | (step ? hit : ev_t'(3'b000));
        end
    end

    assign cnt   = cnt_q;
    assign flags = flags_q;
endmodule

// File: rtl/cmp_timer_irq.sv
module cmp_timer_irq
    import cmp_timer_pkg::*;
(
    input  ev_t              flags,
    input  ev_t              en,
    output logic             irq,
    output logic [VEC_W-1:0] vec
);
    ev_t pend;
    assign pend = flags & en;
    assign irq  = |pend;
    assign vec  = pick_vector(pend);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic [VEC_W-1:0]  irq_vec
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_a_q;
    logic [CNT_W-1:0] cmp_b_q;
    logic             clr_a_q;
    logic             wr_hi;
    logic             wr_lo;
    ev_t              flag_q;
    ev_t              keep;
    ev_t              en_q;

    cmp_timer_regs u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
        .cnt(cnt_q), .flags(flag_q), .rdata(bus_rdata),
        .cnt_wr_hi(wr_hi), .cnt_wr_lo(wr_lo), .keep(keep), .en(en_q),
        .clr_a(clr_a_q), .cmp_a(cmp_a_q), .cmp_b(cmp_b_q)
    );

    cmp_timer_core u_core (
        .clk(clk), .rst(rst), .tick(tick), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .wdata(bus_wdata), .keep(keep), .clr_a(clr_a_q),
        .cmp_a(cmp_a_q), .cmp_b(cmp_b_q), .cnt(cnt_q), .flags(flag_q)
    );

    cmp_timer_irq u_irq (
        .flags(flag_q), .en(en_q), .irq(irq), .vec(irq_vec)
    );
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
    import cmp_timer_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic              irq,
    input logic [VEC_W-1:0]  irq_vec,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  cmp_a_q,
    input logic [CNT_W-1:0]  cmp_b_q,
    input logic              clr_a_q,
    input logic [2:0]        flag_q,
    input logic [2:0]        en_q
);
    logic cnt_wr;
    logic step;
    logic stat_wr;
    assign cnt_wr  = bus_we && (bus_addr == 3'd2 || bus_addr == 3'd3);
    assign step    = tick && !cnt_wr;
    assign stat_wr = bus_we && (bus_addr == 3'd1);

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_wr) |=> $stable(cnt_q));

    assert_match_a_R5: assert property (@(posedge clk) disable iff (rst)
        (step && cnt_q == cmp_a_q) |=> flag_q[0]);

    assert_clear_a_R5: assert property (@(posedge clk) disable iff (rst)
        (step && cnt_q == cmp_a_q && clr_a_q) |=> (cnt_q == 16'd1));

    assert_b_no_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (step && cnt_q == cmp_b_q && !(cnt_q == cmp_a_q && clr_a_q))
        |=> (cnt_q == 16'($past(cnt_q) + 16'd1)) && flag_q[1]);

    assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (step && cnt_q == 16'hFFFF && !(clr_a_q && cmp_a_q == 16'hFFFF))
        |=> (flag_q[2] && cnt_q == 16'd0));

    assert_sticky_a_R8: assert property (@(posedge clk) disable iff (rst)
        (flag_q[0] && !(stat_wr && !bus_wdata[0])) |=> flag_q[0]);

    assert_sticky_b_R8: assert property (@(posedge clk) disable iff (rst)
        (flag_q[1] && !(stat_wr && !bus_wdata[1])) |=> flag_q[1]);

    assert_sticky_ovf_R8: assert property (@(posedge clk) disable iff (rst)
        (flag_q[2] && !(stat_wr && !bus_wdata[2])) |=> flag_q[2]);

    assert_irq_pending_R9: assert property (@(posedge clk) disable iff (rst)
        ((flag_q & en_q) != 3'd0) |-> irq);

    assert_vec_range_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_vec == 5'd16 || irq_vec == 5'd17 || irq_vec == 5'd18));

    assert_vec_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !irq |-> (irq_vec == 5'd0));
endmodule

bind cmp_timer cmp_timer_chk u_chk (
    .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .irq(irq), .irq_vec(irq_vec),
    .cnt_q(cnt_q), .cmp_a_q(cmp_a_q), .cmp_b_q(cmp_b_q), .clr_a_q(clr_a_q),
    .flag_q(flag_q), .en_q(en_q)
);

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic [4:0] irq_vec;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // bench-side expected state
    logic [15:0] m_cnt, m_ca, m_cb;
    logic [2:0]  m_fl, m_en;
    logic        m_clr, m_sel;
    logic [7:0]  m_tctl;

    always #4 clk = ~clk;

    cmp_timer i_cmp_timer (
        .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
        .irq(irq), .irq_vec(irq_vec)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 16'd0; m_ca = 16'hFFFF; m_cb = 16'hFFFF;
        m_fl = 3'd0; m_en = 3'd0; m_clr = 1'b0; m_sel = 1'b0; m_tctl = 8'd0;
    endtask

    task automatic model_clock(input logic w, input logic [2:0] a, input logic [7:0] d, input logic t);
        logic        cw, stp, ha, hb, ho;
        logic [16:0] nxt;
        logic [2:0]  keepm;
        cw  = w && (a == 3'd2 || a == 3'd3);
        stp = t && !cw;
        ha  = (m_cnt == m_ca);
        hb  = (m_cnt == m_cb);
        nxt = ((ha && m_clr) ? 17'd0 : {1'b0, m_cnt}) + 17'd1;
        ho  = nxt[16];
        keepm = (w && a == 3'd1) ? d[2:0] : 3'b111;
        m_fl = (m_fl & keepm) | (stp ? {ho, hb, ha} : 3'b000);
        if (cw) begin
            if (a == 3'd2) m_cnt[15:8] = d; else m_cnt[7:0] = d;
        end else if (stp) begin
            m_cnt = nxt[15:0];
        end
        if (w) begin
            case (a)
                3'd0: m_en = d[2:0];
                3'd1: m_clr = d[3];
                3'd4: if (m_sel) m_cb[15:8] = d; else m_ca[15:8] = d;
                3'd5: if (m_sel) m_cb[7:0] = d; else m_ca[7:0] = d;
                3'd6: m_tctl = d;
                3'd7: m_sel = d[0];
                default: ;
            endcase
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return {5'd0, m_en};
            3'd1: return {4'd0, m_clr, m_fl};
            3'd2: return m_cnt[15:8];
            3'd3: return m_cnt[7:0];
            3'd4: return m_sel ? m_cb[15:8] : m_ca[15:8];
            3'd5: return m_sel ? m_cb[7:0] : m_ca[7:0];
            3'd6: return m_tctl;
            default: return {7'd0, m_sel};
        endcase
    endfunction

    task automatic cyc(input logic w, input logic [2:0] a, input logic [7:0] d, input logic t);
        @(negedge clk);
        bus_we = w; bus_addr = a; bus_wdata = d; tick = t;
        @(posedge clk);
        #1;
        bus_we = 1'b0; tick = 1'b0;
        model_clock(w, a, d, t);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cyc(1'b1, a, d, 1'b0);
    endtask

    task automatic rd_chk(input logic [2:0] a, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp_rd(a));
    endtask

    task automatic irq_chk(input string tag);
        logic [2:0] p;
        int ev;
        @(negedge clk);
        p = m_fl & m_en;
        ev = p[2] ? 18 : p[1] ? 17 : p[0] ? 16 : 0;
        chk({tag, " irq"}, irq, |p);
        chk({tag, " vec"}, irq_vec, ev);
    endtask

    task automatic set_cmp(input logic s, input logic [15:0] v);
        wr(3'd7, {7'd0, s});
        wr(3'd4, v[15:8]);
        wr(3'd5, v[7:0]);
    endtask

    task automatic set_cnt(input logic [15:0] v);
        wr(3'd2, v[15:8]);
        wr(3'd3, v[7:0]);
    endtask

    task automatic ticks_chk(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            cyc(1'b0, 3'd0, 8'd0, 1'b1);
            rd_chk(3'd2, tag);
            rd_chk(3'd3, tag);
            rd_chk(3'd1, tag);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 / R2: reset values through every offset
        for (int a = 0; a < 8; a++) begin
            rd_chk(3'(a), "R1 reset readback");
        end
        irq_chk("R1 reset");

        // R2: layout and storage of plain registers, unused bits read 0
        wr(3'd0, 8'hFF);
        rd_chk(3'd0, "R2 enable bits");
        wr(3'd0, 8'h00);
        wr(3'd6, 8'hA5);
        rd_chk(3'd6, "R2 offset 6 byte");
        wr(3'd7, 8'hFE);
        rd_chk(3'd7, "R2 select bit only");
        wr(3'd1, 8'hFF);
        rd_chk(3'd1, "R2 status layout");
        wr(3'd1, 8'h00);

        // R3: steering of offsets 4 and 5
        set_cmp(1'b0, 16'h1234);
        set_cmp(1'b1, 16'h5678);
        for (int s = 0; s < 2; s++) begin
            wr(3'd7, 8'(s));
            rd_chk(3'd4, "R3 compare high");
            rd_chk(3'd5, "R3 compare low");
        end

        // R4: counter writes, idle cycles and tick/write collision
        set_cnt(16'h0010);
        rd_chk(3'd3, "R4 counter write");
        repeat (4) @(negedge clk);
        rd_chk(3'd3, "R4 idle hold");
        ticks_chk(5, "R4 ticks");
        cyc(1'b1, 3'd3, 8'h40, 1'b1);
        rd_chk(3'd3, "R4 write wins");
        rd_chk(3'd2, "R4 write wins high");
        set_cmp(1'b0, 16'h0040);
        cyc(1'b1, 3'd2, 8'h00, 1'b1);
        rd_chk(3'd1, "R4 suppressed tick leaves flags");

        // R5 / R6: walk through both matches, with and without clear-on-A
        for (int c = 0; c < 2; c++) begin
            set_cmp(1'b0, 16'h0020);
            set_cmp(1'b1, 16'h0022);
            wr(3'd1, {4'd0, 1'(c), 3'b000});
            set_cnt(16'h001E);
            ticks_chk(8, c ? "R5 clear on A walk" : "R6 compare walk");
        end
        // R6: B on the same value as A with clear off
        wr(3'd1, 8'h00);
        set_cmp(1'b0, 16'h0300);
        set_cmp(1'b1, 16'h0300);
        set_cnt(16'h02FF);
        ticks_chk(3, "R6 B and A together");

        // R7: wrap, also when compare A with clear sits at 0xFFFF
        wr(3'd1, 8'h00);
        set_cmp(1'b0, 16'h1111);
        set_cmp(1'b1, 16'h2222);
        set_cnt(16'hFFFD);
        ticks_chk(4, "R7 wrap");
        wr(3'd1, 8'h08);
        set_cmp(1'b0, 16'hFFFF);
        set_cnt(16'hFFFF);
        ticks_chk(2, "R7 clear at top");

        // R8: every write pattern against all-set flags, plus set-beats-clear
        wr(3'd1, 8'h00);
        set_cmp(1'b0, 16'hFFFF);
        set_cmp(1'b1, 16'hFFFF);
        for (int p = 0; p < 8; p++) begin
            set_cnt(16'hFFFF);
            cyc(1'b0, 3'd0, 8'd0, 1'b1);
            rd_chk(3'd1, "R8 all flags set");
            wr(3'd1, 8'(p));
            rd_chk(3'd1, "R8 write-0 clears");
        end
        set_cnt(16'hFFFF);
        cyc(1'b1, 3'd1, 8'h00, 1'b1);
        rd_chk(3'd1, "R8 event beats clear");

        // R9 / R10: all enable and flag combinations
        for (int e = 0; e < 8; e++) begin
            for (int f = 0; f < 8; f++) begin
                wr(3'd1, 8'h00);
                set_cnt(16'hFFFF);
                cyc(1'b0, 3'd0, 8'd0, 1'b1);
                wr(3'd1, 8'(f));
                wr(3'd0, 8'(e));
                irq_chk("R9 R10 sweep");
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule